// File: doc/BRIEF.md
# PC Card Socket Glue Logic

This block sits between the PC Card port of a host memory controller and one or two 16-bit PC Card sockets. From the host side it takes a socket-select line, the read/not-write direction, the two active-low chip enables, the address LSB and the two active-low I/O strobes. It produces per-socket transceiver enables, a common transceiver direction, a three-state control for the address and write-strobe lines (which other memories share), and a copy of the chip enables and strobes routed to the chosen socket. The sockets that are not chosen stay at their idle levels.

The card's wait and I/O-width feedback lines pass through a synchronizer. They reach the host only when two conditions hold: software has marked the chosen socket's card as present, and that socket's card-detect pin is active. A cycle decoder turns the chip-enable and strobe pattern into byte-lane enables, an odd-byte indicator and read/write flags. A pattern that is not a legal cycle raises a flag and enables no lane.

A small control register holds the socket count, the per-socket card-present bits, the per-socket drive enables and the per-socket card reset outputs. It loads in one cycle when its write strobe is high.

Top module: `pcc_socket_glue`

## Requirements
- R1: In one-socket mode, xcvr_oe_n[0] is low exactly when host_sock_sel is 1 and drive enable 0 is set. xcvr_oe_n[1] stays high.
- R2: xcvr_dir equals host_rd_nwr in the same cycle, where 1 means card-to-host.
- R3: addr_oe_n is low only while host_addr_drv_req is 1 and at least one drive-enable bit is set.
- R4: When the card-present bit of the active socket is 0, host_wait_n and host_iois16_n are both 1. The active socket is host_sock_sel in two-socket mode and socket 0 in one-socket mode.
- R5: When card_detect_n of the active socket is 1, host_wait_n and host_iois16_n are both 1.
- R6: When both gates are open, host_wait_n and host_iois16_n carry the active socket's card_wait_n and card_iois16_n as they were captured two rising clock edges earlier.
- R7: The chosen socket's sock_ce1_n, sock_ce2_n, sock_ior_n and sock_iow_n copy the host lines when its drive enable is set. Every other socket holds these lines at 1 and keeps its xcvr_oe_n high. In two-socket mode, the chosen socket's transceiver is enabled only while a host chip enable is low.
- R8: 8-bit I/O write: host_ce2_n=1, host_ce1_n=0, host_iow_n=0 and host_ior_n=1 give lane_lo_en=1, lane_hi_en=0, io_write=1 and odd_byte=host_a0.
- R9: 8-bit I/O read: host_ce2_n=1, host_ce1_n=0, host_ior_n=0 and host_iow_n=1 give lane_lo_en=1, lane_hi_en=0, io_read=1 and odd_byte=host_a0.
- R10: Both chip enables low, one strobe low, host_a0=0 and host_iois16_n=0 give a word cycle with both lanes enabled and odd_byte=0. host_ce2_n=0 with host_ce1_n=1 and one strobe low gives a high-lane odd-byte cycle: lane_hi_en=1, lane_lo_en=0, odd_byte=1.
- R11: The following patterns raise bad_cycle and enable no lane, no io_read and no io_write: both strobes low; a strobe low with both chip enables high; or a word pattern with host_a0=1 or host_iois16_n=1. With both strobes high, every decode output is 0.
- R12: The control register fields are ctl_wdata[6:5] card reset, [4:3] drive enable, [2:1] card present and [0] socket count (1 = two sockets). After reset all fields are 0, so every socket line is idle and sock_reset=0. A write takes effect on the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control register write data |
| host_sock_sel | input | 1 | Socket select / transceiver request from host |
| host_rd_nwr | input | 1 | Host direction, 1 = read |
| host_ce1_n | input | 1 | Host chip enable 1, active low |
| host_ce2_n | input | 1 | Host chip enable 2, active low |
| host_a0 | input | 1 | Host address LSB |
| host_ior_n | input | 1 | Host I/O read strobe, active low |
| host_iow_n | input | 1 | Host I/O write strobe, active low |
| host_addr_drv_req | input | 1 | Request to drive shared address and write-strobe lines |
| card_detect_n | input | 2 | Per-socket card detect, active low |
| card_wait_n | input | 2 | Per-socket card wait, active low |
| card_iois16_n | input | 2 | Per-socket 16-bit I/O indication, active low |
| xcvr_oe_n | output | 2 | Per-socket data transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = card to host |
| addr_oe_n | output | 1 | Address and write-strobe buffer enable, active low |
| sock_ce1_n | output | 2 | Routed chip enable 1 per socket |
| sock_ce2_n | output | 2 | Routed chip enable 2 per socket |
| sock_ior_n | output | 2 | Routed I/O read strobe per socket |
| sock_iow_n | output | 2 | Routed I/O write strobe per socket |
| sock_reset | output | 2 | Card reset per socket, active high |
| host_wait_n | output | 1 | Gated, synchronized wait to host |
| host_iois16_n | output | 1 | Gated, synchronized I/O width to host |
| lane_lo_en | output | 1 | Low data byte lane in use |
| lane_hi_en | output | 1 | High data byte lane in use |
| odd_byte | output | 1 | Byte carried is the odd byte |
| io_read | output | 1 | Valid I/O read cycle decoded |
| io_write | output | 1 | Valid I/O write cycle decoded |
| bad_cycle | output | 1 | Chip-enable/strobe pattern is not a valid cycle |

## Verification
The hardest situation to reach is a legal 16-bit word cycle. It needs all of the following at once: two-socket or one-socket mode with the chosen socket's card-present bit set, its card-detect low, and its I/O-width line held low for two clock edges before both chip enables drop with host_a0=0. Purely random stimulus seldom lines these up. The bench therefore first programs the register to open every gate, holds the width line low across several idle cycles, and then issues word, misaligned-word, 8-bit and odd-byte cycles. After that it hands over to seeded random traffic that rewrites the register about every tenth cycle, keeps card detect mostly present, and lets a bench model track the two-edge synchronizer delay.

// File: rtl/pcc_glue_pkg.sv
package pcc_glue_pkg;
  localparam int NSOCK = 2;
  localparam int CTL_W = 1 + 3 * NSOCK;

  typedef struct packed {
    logic [NSOCK-1:0] card_rst;
    logic [NSOCK-1:0] drv_en;
    logic [NSOCK-1:0] present;
    logic             two_sock;
  } ctl_t;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_IO8   = 3'd1,
    CYC_WORD  = 3'd2,
    CYC_HIODD = 3'd3,
    CYC_BAD   = 3'd4
  } cyc_e;

  function automatic cyc_e classify(input logic ce2_n, input logic ce1_n,
                                    input logic ior_n, input logic iow_n,
                                    input logic a0, input logic is16_n);
    cyc_e k;
    if (ior_n && iow_n) k = CYC_IDLE;
    else if (!ior_n && !iow_n) k = CYC_BAD;
    else begin
      unique case ({ce2_n, ce1_n})
        2'b10:   k = CYC_IO8;
        2'b00:   k = (!is16_n && !a0) ? CYC_WORD : CYC_BAD;
        2'b01:   k = CYC_HIODD;
        default: k = CYC_BAD;
      endcase
    end
    return k;
  endfunction

  // {lo, hi, odd}
  function automatic logic [2:0] lanes_of(input cyc_e k, input logic a0);
    logic [2:0] r;
    unique case (k)
      CYC_IO8:   r = {1'b1, 1'b0, a0};
      CYC_WORD:  r = 3'b110;
      CYC_HIODD: r = 3'b011;
      default:   r = 3'b000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pcc_ctl_regs.sv
module pcc_ctl_regs
  import pcc_glue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (we) ctl <= ctl_t'(wdata);
  end
endmodule

// File: rtl/pcc_fb_sync.sv
module pcc_fb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '1;
    else chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '1;
      else chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcc_sock_route.sv
module pcc_sock_route
  import pcc_glue_pkg::*;
(
  input  logic             two_sock,
  input  logic [NSOCK-1:0] drv_en,
  input  logic             act_sock,
  input  logic             sel,
  input  logic             ce1_n,
  input  logic             ce2_n,
  input  logic             ior_n,
  input  logic             iow_n,
  output logic [NSOCK-1:0] xcvr_oe_n,
  output logic [NSOCK-1:0] s_ce1_n,
  output logic [NSOCK-1:0] s_ce2_n,
  output logic [NSOCK-1:0] s_ior_n,
  output logic [NSOCK-1:0] s_iow_n
);
  logic xcvr_go;
  logic [NSOCK-1:0] sock_on;

  assign xcvr_go = two_sock ? (!ce1_n || !ce2_n) : sel;

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    assign sock_on[s]   = drv_en[s] && (int'(act_sock) == s);
    assign xcvr_oe_n[s] = !(sock_on[s] && xcvr_go);
    assign s_ce1_n[s]   = sock_on[s] ? ce1_n : 1'b1;
    assign s_ce2_n[s]   = sock_on[s] ? ce2_n : 1'b1;
    assign s_ior_n[s]   = sock_on[s] ? ior_n : 1'b1;
    assign s_iow_n[s]   = sock_on[s] ? iow_n : 1'b1;
  end
endmodule

// File: rtl/pcc_cycle_decode.sv
module pcc_cycle_decode
  import pcc_glue_pkg::*;
(
  input  logic ce1_n,
  input  logic ce2_n,
  input  logic ior_n,
  input  logic iow_n,
  input  logic a0,
  input  logic is16_n,
  output cyc_e kind,
  output logic lo_en,
  output logic hi_en,
  output logic odd,
  output logic rd,
  output logic wr,
  output logic bad
);
  logic valid;

  assign kind  = classify(ce2_n, ce1_n, ior_n, iow_n, a0, is16_n);
  assign {lo_en, hi_en, odd} = lanes_of(kind, a0);
  assign valid = (kind != CYC_IDLE) && (kind != CYC_BAD);
  assign rd    = valid && !ior_n;
  assign wr    = valid && !iow_n;
  assign bad   = (kind == CYC_BAD);
endmodule

// File: rtl/pcc_socket_glue.sv
module pcc_socket_glue
  import pcc_glue_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             host_sock_sel,
  input  logic             host_rd_nwr,
  input  logic             host_ce1_n,
  input  logic             host_ce2_n,
  input  logic             host_a0,
  input  logic             host_ior_n,
  input  logic             host_iow_n,
  input  logic             host_addr_drv_req,
  input  logic [NSOCK-1:0] card_detect_n,
  input  logic [NSOCK-1:0] card_wait_n,
  input  logic [NSOCK-1:0] card_iois16_n,
  output logic [NSOCK-1:0] xcvr_oe_n,
  output logic             xcvr_dir,
  output logic             addr_oe_n,
  output logic [NSOCK-1:0] sock_ce1_n,
  output logic [NSOCK-1:0] sock_ce2_n,
  output logic [NSOCK-1:0] sock_ior_n,
  output logic [NSOCK-1:0] sock_iow_n,
  output logic [NSOCK-1:0] sock_reset,
  output logic             host_wait_n,
  output logic             host_iois16_n,
  output logic             lane_lo_en,
  output logic             lane_hi_en,
  output logic             odd_byte,
  output logic             io_read,
  output logic             io_write,
  output logic             bad_cycle
);
  ctl_t             ctl;
  logic             act_sock;
  logic             fb_open;
  logic [NSOCK-1:0] wait_s;
  logic [NSOCK-1:0] width_s;
  logic [NSOCK-1:0] ctl_present;
  cyc_e             cyc_kind;

  pcc_ctl_regs i_regs (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .ctl(ctl)
  );

  pcc_fb_sync #(.W(NSOCK), .STAGES(SYNC_STAGES)) i_sync_wait (
    .clk(clk), .rst_n(rst_n), .d(card_wait_n), .q(wait_s)
  );

  pcc_fb_sync #(.W(NSOCK), .STAGES(SYNC_STAGES)) i_sync_width (
    .clk(clk), .rst_n(rst_n), .d(card_iois16_n), .q(width_s)
  );

  assign ctl_present   = ctl.present;
  assign act_sock      = ctl.two_sock ? host_sock_sel : 1'b0;
  assign fb_open       = ctl.present[act_sock] && !card_detect_n[act_sock];
  assign host_wait_n   = fb_open ? wait_s[act_sock]  : 1'b1;
  assign host_iois16_n = fb_open ? width_s[act_sock] : 1'b1;

  assign xcvr_dir   = host_rd_nwr;
  assign addr_oe_n  = !(host_addr_drv_req && (|ctl.drv_en));
  assign sock_reset = ctl.card_rst;

  pcc_sock_route i_route (
    .two_sock(ctl.two_sock), .drv_en(ctl.drv_en), .act_sock(act_sock),
    .sel(host_sock_sel), .ce1_n(host_ce1_n), .ce2_n(host_ce2_n),
    .ior_n(host_ior_n), .iow_n(host_iow_n), .xcvr_oe_n(xcvr_oe_n),
    .s_ce1_n(sock_ce1_n), .s_ce2_n(sock_ce2_n),
    .s_ior_n(sock_ior_n), .s_iow_n(sock_iow_n)
  );

  pcc_cycle_decode i_dec (
    .ce1_n(host_ce1_n), .ce2_n(host_ce2_n), .ior_n(host_ior_n),
    .iow_n(host_iow_n), .a0(host_a0), .is16_n(host_iois16_n),
    .kind(cyc_kind), .lo_en(lane_lo_en), .hi_en(lane_hi_en),
    .odd(odd_byte), .rd(io_read), .wr(io_write), .bad(bad_cycle)
  );
endmodule

// File: rtl/pcc_glue_checker.sv
module pcc_glue_checker
  import pcc_glue_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             two_sock,
  input logic             act_sock,
  input logic [NSOCK-1:0] ctl_present,
  input logic             ctl_we,
  input logic             host_sock_sel,
  input logic             host_ce1_n,
  input logic             host_ce2_n,
  input logic             host_a0,
  input logic             host_ior_n,
  input logic             host_iow_n,
  input logic             host_addr_drv_req,
  input logic [NSOCK-1:0] card_detect_n,
  input logic [NSOCK-1:0] xcvr_oe_n,
  input logic             addr_oe_n,
  input logic [NSOCK-1:0] sock_ior_n,
  input logic [NSOCK-1:0] sock_iow_n,
  input logic [NSOCK-1:0] sock_reset,
  input logic             host_wait_n,
  input logic             host_iois16_n,
  input logic             lane_lo_en,
  input logic             lane_hi_en,
  input logic             odd_byte,
  input logic             io_read,
  input logic             io_write,
  input logic             bad_cycle
);
  AST_XCVR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_sock && !host_sock_sel) |-> xcvr_oe_n[0]); // R1
  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_addr_drv_req |-> addr_oe_n); // R3
  AST_FB_MASK_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_present[act_sock] |-> (host_wait_n && host_iois16_n)); // R4
  AST_FB_MASK_NODETECT: assert property (@(posedge clk) disable iff (!rst_n)
    card_detect_n[act_sock] |-> (host_wait_n && host_iois16_n)); // R5
  AST_ONE_XCVR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~xcvr_oe_n) <= 1); // R7
  AST_SOCK1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !two_sock |-> (xcvr_oe_n[1] && sock_ior_n[1] && sock_iow_n[1])); // R7
  AST_IO8_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ce2_n && !host_ce1_n && (host_ior_n != host_iow_n))
      |-> (lane_lo_en && !lane_hi_en && (odd_byte == host_a0))); // R8
  AST_BAD_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cycle |-> (!lane_lo_en && !lane_hi_en && !io_read && !io_write)); // R11
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_we) |-> $stable(sock_reset)); // R12
endmodule

bind pcc_socket_glue pcc_glue_checker i_chk (
  .clk(clk), .rst_n(rst_n), .two_sock(ctl.two_sock), .act_sock(act_sock),
  .ctl_present(ctl_present), .ctl_we(ctl_we), .host_sock_sel(host_sock_sel),
  .host_ce1_n(host_ce1_n), .host_ce2_n(host_ce2_n), .host_a0(host_a0),
  .host_ior_n(host_ior_n), .host_iow_n(host_iow_n),
  .host_addr_drv_req(host_addr_drv_req), .card_detect_n(card_detect_n),
  .xcvr_oe_n(xcvr_oe_n), .addr_oe_n(addr_oe_n), .sock_ior_n(sock_ior_n),
  .sock_iow_n(sock_iow_n), .sock_reset(sock_reset), .host_wait_n(host_wait_n),
  .host_iois16_n(host_iois16_n), .lane_lo_en(lane_lo_en),
  .lane_hi_en(lane_hi_en), .odd_byte(odd_byte), .io_read(io_read),
  .io_write(io_write), .bad_cycle(bad_cycle)
);

// File: tb/test_pcc_socket_glue.sv
module test_pcc_socket_glue;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic sel = 0, rd_nwr = 0, ce1_n = 1, ce2_n = 1, a0 = 0, ior_n = 1, iow_n = 1;
  logic addr_req = 0;
  logic [1:0] cd_n = 2'b11, cw_n = 2'b11, ci_n = 2'b11;

  logic [1:0] xcvr_oe_n, sock_ce1_n, sock_ce2_n, sock_ior_n, sock_iow_n, sock_reset;
  logic xcvr_dir, addr_oe_n, host_wait_n, host_iois16_n;
  logic lane_lo_en, lane_hi_en, odd_byte, io_read, io_write, bad_cycle;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  logic [6:0] m_ctl = '0;
  logic [1:0] m_w1 = 2'b11, m_w2 = 2'b11, m_i1 = 2'b11, m_i2 = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcc_socket_glue i_pcc_socket_glue (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .host_sock_sel(sel), .host_rd_nwr(rd_nwr), .host_ce1_n(ce1_n),
    .host_ce2_n(ce2_n), .host_a0(a0), .host_ior_n(ior_n), .host_iow_n(iow_n),
    .host_addr_drv_req(addr_req), .card_detect_n(cd_n), .card_wait_n(cw_n),
    .card_iois16_n(ci_n), .xcvr_oe_n(xcvr_oe_n), .xcvr_dir(xcvr_dir),
    .addr_oe_n(addr_oe_n), .sock_ce1_n(sock_ce1_n), .sock_ce2_n(sock_ce2_n),
    .sock_ior_n(sock_ior_n), .sock_iow_n(sock_iow_n), .sock_reset(sock_reset),
    .host_wait_n(host_wait_n), .host_iois16_n(host_iois16_n),
    .lane_lo_en(lane_lo_en), .lane_hi_en(lane_hi_en), .odd_byte(odd_byte),
    .io_read(io_read), .io_write(io_write), .bad_cycle(bad_cycle)
  );

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at %0t", what, got, exp, $time);
    end
  endtask

  // expected lane triple {lo, hi, odd, rd, wr, bad}
  function automatic logic [5:0] exp_dec(input logic is16_n);
    logic lo, hi, od, bad, act;
    lo = 0; hi = 0; od = 0; bad = 0;
    act = !ior_n || !iow_n;
    if (!ior_n && !iow_n) bad = 1;
    else if (act) begin
      if (ce2_n && !ce1_n) begin lo = 1; od = a0; end
      else if (!ce2_n && ce1_n) begin hi = 1; od = 1; end
      else if (!ce2_n && !ce1_n && !a0 && !is16_n) begin lo = 1; hi = 1; end
      else bad = 1;
    end
    return {lo, hi, od, act && !bad && !ior_n, act && !bad && !iow_n, bad};
  endfunction

  task automatic check_all(input string tag);
    logic two, s, open, go;
    logic [1:0] drv, pres, on, ex;
    logic ew, ei;
    two  = m_ctl[0];
    pres = m_ctl[2:1];
    drv  = m_ctl[4:3];
    s    = two ? sel : 1'b0;
    on   = 2'b00;
    on[s] = drv[s];
    go   = two ? (!ce1_n || !ce2_n) : sel;
    ex   = ~(on & {go, go});
    open = pres[s] && !cd_n[s];
    ew   = open ? m_w2[s] : 1'b1;
    ei   = open ? m_i2[s] : 1'b1;
    chk({tag, " R1/R7 xcvr_oe_n"}, {6'd0, xcvr_oe_n}, {6'd0, ex});
    chk({tag, " R2 xcvr_dir"}, {7'd0, xcvr_dir}, {7'd0, rd_nwr});
    chk({tag, " R3 addr_oe_n"}, {7'd0, addr_oe_n}, {7'd0, !(addr_req && drv != 0)});
    chk({tag, " R7 sock strobes"}, {sock_ce1_n, sock_ce2_n, sock_ior_n, sock_iow_n},
        {on[1] ? ce1_n : 1'b1, on[0] ? ce1_n : 1'b1, on[1] ? ce2_n : 1'b1, on[0] ? ce2_n : 1'b1,
         on[1] ? ior_n : 1'b1, on[0] ? ior_n : 1'b1, on[1] ? iow_n : 1'b1, on[0] ? iow_n : 1'b1});
    chk({tag, " R4/R5/R6 host_wait_n"}, {7'd0, host_wait_n}, {7'd0, ew});
    chk({tag, " R4/R5/R6 host_iois16_n"}, {7'd0, host_iois16_n}, {7'd0, ei});
    chk({tag, " R8/R9/R10/R11 decode"},
        {2'd0, lane_lo_en, lane_hi_en, odd_byte, io_read, io_write, bad_cycle},
        {2'd0, exp_dec(ei)});
    chk({tag, " R12 sock_reset"}, {6'd0, sock_reset}, {6'd0, m_ctl[6:5]});
  endtask

  // inputs already set at a negedge; model the coming posedge, then check
  task automatic step(input string tag);
    m_w2 = m_w1; m_w1 = cw_n;
    m_i2 = m_i1; m_i1 = ci_n;
    if (ctl_we) m_ctl = ctl_wdata;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic set_cyc(input logic c2, input logic c1, input logic r, input logic w,
                         input logic a);
    ce2_n = c2; ce1_n = c1; ior_n = r; iow_n = w; a0 = a; rd_nwr = !r;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R12 reset");

    // R12: write takes effect on the next cycle, open every gate, two sockets
    ctl_we = 1; ctl_wdata = 7'b01_11_11_1;
    cd_n = 2'b00; ci_n = 2'b00; cw_n = 2'b10; addr_req = 1;
    step("R12 ctl write");
    ctl_we = 0;
    sel = 0;
    for (int k = 0; k < 3; k++) step("R6 settle");
    // R10 word read on socket 0
    set_cyc(0, 0, 0, 1, 0); step("R10 word");
    // R11 misaligned word
    set_cyc(0, 0, 0, 1, 1); step("R11 odd word");
    // R8 8-bit writes, even and odd
    set_cyc(1, 0, 1, 0, 0); step("R8 even");
    set_cyc(1, 0, 1, 0, 1); step("R8 odd");
    // R9 8-bit reads
    set_cyc(1, 0, 0, 1, 0); step("R9 even");
    set_cyc(1, 0, 0, 1, 1); step("R9 odd");
    // R10 high-lane odd byte
    set_cyc(0, 1, 0, 1, 0); step("R10 hi odd");
    // R11 both strobes low, and strobe with no chip enable
    set_cyc(1, 0, 0, 0, 0); step("R11 both");
    set_cyc(1, 1, 1, 0, 0); step("R11 noce");
    // R7 socket 1, R5 its card missing
    sel = 1; cd_n = 2'b10; set_cyc(1, 0, 1, 0, 0); step("R5/R7 sock1");
    // R4 card-present cleared, R1 one-socket mode
    ctl_we = 1; ctl_wdata = 7'b10_01_00_0; step("R4 absent");
    ctl_we = 0; sel = 0; step("R1 sel off");
    sel = 1; step("R1 sel on");

    for (int i = 0; i < 4000; i++) begin
      int r;
      ctl_we = ($urandom % 10) == 0;
      ctl_wdata = 7'($urandom);
      if (($urandom % 3) != 0) ctl_wdata[2:1] = 2'b11;
      sel = 1'($urandom); addr_req = 1'($urandom); a0 = 1'($urandom);
      {ce2_n, ce1_n} = 2'($urandom);
      r = $urandom % 8;
      {ior_n, iow_n} = (r < 3) ? 2'b11 : (r < 5) ? 2'b01 : (r < 7) ? 2'b10 : 2'b00;
      rd_nwr = 1'($urandom);
      cd_n[0] = ($urandom % 4) == 0;
      cd_n[1] = ($urandom % 4) == 0;
      if (($urandom % 4) == 0) cw_n = 2'($urandom);
      if (($urandom % 4) == 0) ci_n = 2'($urandom);
      step("rand");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule